// File: doc/BRIEF.md
# Overlapped Block Input Sequencer

This block decides when incoming samples are written into a transform buffer and at which address. It sits between a sample strobe and an on-chip sample RAM. For each load it produces a write enable and a write address, a load flag that shows when a normal-size block is being filled, and a one-cycle completion pulse. The RAM, the transform engine and the output side are not part of it.

A mode word sets three things: the block size, the overlap between successive blocks (none, half or three quarters), and whether the extended-load scheme is used. With half overlap the incoming strobe is divided by two, and with three-quarter overlap it is divided by four. This lets the input and output sides run from one common clock source while the input is accepted at the lower rate. In the extended-load scheme the sequencer keeps capturing one extra hop of samples after the normal block is complete. That gives the downstream engine enough data for two overlapped transforms without a new load. Size and overlap combinations that are not allowed raise an error output, and a start request is then ignored.

Samples arrive on a valid/ready pair. `samp_valid` is the raw input strobe: one pulse per sample, which the source does not hold. A sample transfers in any cycle where `samp_valid` and `samp_ready` are both high. A strobe seen while `samp_ready` is low is lost. It is not retried, although it still advances the divider phase while a load is active.

Top module: `ovl_load_seq`

## Requirements
- R1: Size code `size_sel` selects the block length N: codes 0..4 give 64, 128, 256, 512 and 1024 points; code 5 is the 16 x 16 complex form with 256 points; codes 6 and 7 are illegal.
- R2: Overlap code `ovl_sel` 0, 1 and 2 selects 0%, 50% and 75% overlap, with strobe division 1, 2 and 4. When the strobe pulses every cycle, consecutive writes are exactly that many cycles apart.
- R3: A sample is accepted only when `samp_valid` and `samp_ready` are both high. `samp_ready` is high only during an active load, with `in_en` high, on the divider's zero phase.
- R4: Each accepted sample gives `wr_en` high for one cycle on the next cycle, with `wr_addr` equal to a running pointer. The pointer rises by one per write, wraps modulo the buffer depth (2048), and carries over from one load to the next.
- R5: With `ext_load` low, a load writes exactly N samples.
- R6: With `ext_load` high, a load writes N + N/2 samples at 50% overlap, N + N/4 at 75% overlap, and N at 0% overlap (256 at 50% gives 384; 256 at 75% gives 320, five 64-point quarters).
- R7: `load_flag` rises together with the first write of a load and falls together with the N-th write, whether or not the load is extended.
- R8: `block_done` pulses for one cycle together with the final write, and no further writes follow until a new `start`.
- R9: `cfg_err` is high for size codes 6 and 7, for overlap code 3, for the 16 x 16 size with any overlap, and for 1024 points with overlap while `ext_load` is high. A `start` presented while `cfg_err` is high starts nothing.
- R10: Synchronous `srst` clears the divider phase, the write pointer, the load flag and any load in progress, and leaves `wr_en`, `block_done` and `wr_addr` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a load with the current mode |
| size_sel | input | 3 | Block size code |
| ovl_sel | input | 2 | Overlap code |
| ext_load | input | 1 | Selects extended loading |
| in_en | input | 1 | Input enable gating acceptance |
| samp_valid | input | 1 | Input sample strobe |
| samp_ready | output | 1 | Sequencer can take the strobe this cycle |
| wr_en | output | 1 | Sample RAM write enable |
| wr_addr | output | 11 | Sample RAM write address |
| load_flag | output | 1 | Normal-size block being filled |
| block_done | output | 1 | Final write of the load |
| cfg_err | output | 1 | Illegal mode combination |

## Verification
The assertions check, on every cycle, that the write pointer steps by one per accepted sample, that the divider keeps a gap after each accepted strobe, that the load flag changes only together with a write, that the completion pulse lasts one cycle and ends the load, and that reset and an illegal mode leave the write side quiet. The exact load lengths for each size, overlap and extension setting, the N-th-write position of the flag's fall, and pointer continuity across loads and through the wrap need the bench's scenarios, which count writes and compare addresses against an independent pointer.

// File: rtl/ovl_seq_pkg.sv
package ovl_seq_pkg;
  typedef enum logic [1:0] {
    OV_NONE    = 2'd0,
    OV_HALF    = 2'd1,
    OV_QUARTER = 2'd2,
    OV_BAD     = 2'd3
  } ovl_e;
endpackage

// File: rtl/ovl_cfg_decode.sv
module ovl_cfg_decode
  import ovl_seq_pkg::*;
#(
  parameter int BASE_PTS  = 64,
  parameter int NUM_SIZES = 5,
  parameter int SQ_PTS    = 256,
  parameter int CW        = 12
) (
  input  logic [2:0]    size_sel,
  input  logic [1:0]    ovl_sel,
  input  logic          ext_load,
  output logic [CW-1:0] n_pts,
  output logic [CW-1:0] load_len,
  output logic [1:0]    div_log,
  output logic          bad
);
  localparam logic [2:0] SQ_CODE  = 3'(NUM_SIZES);
  localparam logic [2:0] TOP_CODE = 3'(NUM_SIZES - 1);

  logic [CW-1:0] hop;
  ovl_e          ov;

  assign ov = ovl_e'(ovl_sel);

  always_comb begin
    if (size_sel == SQ_CODE) n_pts = CW'(SQ_PTS);
    else                     n_pts = CW'(BASE_PTS) << size_sel;
  end

  always_comb begin
    unique case (ov)
      OV_HALF:    div_log = 2'd1;
      OV_QUARTER: div_log = 2'd2;
      default:    div_log = 2'd0;
    endcase
  end

  assign hop      = n_pts >> div_log;
  assign load_len = (ext_load && div_log != 2'd0) ? n_pts + hop : n_pts;

  always_comb begin
    bad = 1'b0;
    if (size_sel > SQ_CODE)                                   bad = 1'b1;
    if (ov == OV_BAD)                                         bad = 1'b1;
    if (size_sel == SQ_CODE && ov != OV_NONE)                 bad = 1'b1;
    if (ext_load && size_sel == TOP_CODE && ov != OV_NONE)    bad = 1'b1;
  end
endmodule

// File: rtl/ovl_strobe_div.sv
module ovl_strobe_div (
  input  logic       clk,
  input  logic       srst,
  input  logic       clear,
  input  logic       run,
  input  logic       stb,
  input  logic [1:0] div_log,
  output logic       phase_zero
);
  logic [1:0] phase_q;
  logic [1:0] mask;

  always_comb begin
    unique case (div_log)
      2'd1:    mask = 2'b01;
      2'd2:    mask = 2'b11;
      default: mask = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst || clear)    phase_q <= '0;
    else if (run && stb)  phase_q <= (phase_q + 2'd1) & mask;
  end

  assign phase_zero = (phase_q == 2'd0);

  // R2: phase never leaves the range set by the division factor
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (srst)
    run |-> ((phase_q & ~mask) == 2'b00));
endmodule

// File: rtl/ovl_addr_gen.sv
module ovl_addr_gen #(
  parameter int AW = 11,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          load_start,
  input  logic          accept,
  input  logic [CW-1:0] n_pts,
  input  logic [CW-1:0] load_len,
  output logic          last_smp,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          load_flag,
  output logic          done
);
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx   = cnt_q + 1'b1;
  assign last_smp = (cnt_nx == load_len);

  always_ff @(posedge clk) begin
    if (srst) begin
      ptr_q     <= '0;
      cnt_q     <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      load_flag <= 1'b0;
      done      <= 1'b0;
    end else begin
      wr_en <= accept;
      done  <= accept && last_smp;
      if (load_start) cnt_q <= '0;
      if (accept) begin
        wr_addr <= ptr_q;
        ptr_q   <= ptr_q + 1'b1;
        cnt_q   <= cnt_nx;
        if (cnt_nx == n_pts)    load_flag <= 1'b0;
        else if (cnt_q == '0)   load_flag <= 1'b1;
      end
    end
  end

  // R4: pointer advances by exactly one per accepted sample
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (srst)
    accept |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R4: pointer holds when nothing is accepted
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (srst)
    !accept |=> $stable(ptr_q));
  // R7: flag only rises together with a write
  a_r7_flag_rise: assert property (@(posedge clk) disable iff (srst)
    $rose(load_flag) |-> wr_en);
  // R7: flag only falls together with a write (outside reset)
  a_r7_flag_fall: assert property (@(posedge clk) disable iff (srst)
    ($fell(load_flag) && !$past(srst)) |-> wr_en);
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (srst)
    done |=> !done);
endmodule

// File: rtl/ovl_load_seq.sv
module ovl_load_seq
  import ovl_seq_pkg::*;
#(
  parameter  int BASE_PTS  = 64,
  parameter  int NUM_SIZES = 5,
  parameter  int SQ_PTS    = 256,
  parameter  int DEPTH     = 2048,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = $clog2(BASE_PTS << NUM_SIZES) + 1
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          start,
  input  logic [2:0]    size_sel,
  input  logic [1:0]    ovl_sel,
  input  logic          ext_load,
  input  logic          in_en,
  input  logic          samp_valid,
  output logic          samp_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          load_flag,
  output logic          block_done,
  output logic          cfg_err
);
  logic [CW-1:0] dec_n, dec_len;
  logic [1:0]    dec_div;
  logic          dec_bad;

  logic [CW-1:0] n_q, len_q;
  logic [1:0]    div_q;
  logic          active_q;
  logic          start_ok;
  logic          phase_zero;
  logic          accept;
  logic          last_smp;

  ovl_cfg_decode #(
    .BASE_PTS (BASE_PTS),
    .NUM_SIZES(NUM_SIZES),
    .SQ_PTS   (SQ_PTS),
    .CW       (CW)
  ) u_dec (
    .size_sel(size_sel),
    .ovl_sel (ovl_sel),
    .ext_load(ext_load),
    .n_pts   (dec_n),
    .load_len(dec_len),
    .div_log (dec_div),
    .bad     (dec_bad)
  );

  assign cfg_err  = dec_bad;
  assign start_ok = start && !active_q && !dec_bad;

  always_ff @(posedge clk) begin
    if (srst) begin
      active_q <= 1'b0;
      n_q      <= '0;
      len_q    <= '0;
      div_q    <= '0;
    end else if (start_ok) begin
      active_q <= 1'b1;
      n_q      <= dec_n;
      len_q    <= dec_len;
      div_q    <= dec_div;
    end else if (accept && last_smp) begin
      active_q <= 1'b0;
    end
  end

  ovl_strobe_div u_div (
    .clk       (clk),
    .srst      (srst),
    .clear     (start_ok),
    .run       (active_q),
    .stb       (samp_valid),
    .div_log   (div_q),
    .phase_zero(phase_zero)
  );

  assign samp_ready = active_q && in_en && phase_zero;
  assign accept     = samp_valid && samp_ready;

  ovl_addr_gen #(
    .AW(AW),
    .CW(CW)
  ) u_addr (
    .clk       (clk),
    .srst      (srst),
    .load_start(start_ok),
    .accept    (accept),
    .n_pts     (n_q),
    .load_len  (len_q),
    .last_smp  (last_smp),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .load_flag (load_flag),
    .done      (block_done)
  );

  // R2: after an accepted strobe with division, the next cycle cannot accept
  a_r2_spacing: assert property (@(posedge clk) disable iff (srst)
    (accept && div_q != 2'd0) |=> !accept);
  // R3: ready never shows while the input is disabled
  a_r3_ready_gated: assert property (@(posedge clk) disable iff (srst)
    !in_en |-> !samp_ready);
  // R8: completion ends the load
  a_r8_done_idle: assert property (@(posedge clk) disable iff (srst)
    block_done |-> !active_q);
  // R9: a start on an illegal mode from idle produces no write
  a_r9_bad_start: assert property (@(posedge clk) disable iff (srst)
    (start && dec_bad && !active_q) |=> (!wr_en && !active_q));
  // R10: reset leaves the write side cleared
  a_r10_clear: assert property (@(posedge clk)
    srst |=> (!load_flag && !wr_en && !block_done && wr_addr == '0));
endmodule

// File: tb/ovl_load_seq_tb.sv
module ovl_load_seq_tb;
  localparam int AW = 11;

  typedef struct packed {
    logic [2:0]  size;
    logic [1:0]  ovl;
    logic        ext;
    logic        err;
    int unsigned len;
    int unsigned npts;
    int unsigned dv;
  } vec_t;

  // size, ovl, ext, err, writes, N, strobe division
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 1'b0, 1'b0, 64,   64,   1},  // R1 R5 smallest size
    '{3'd2, 2'd1, 1'b1, 1'b0, 384,  256,  2},  // R6 256 + 128
    '{3'd2, 2'd2, 1'b1, 1'b0, 320,  256,  4},  // R6 five quarters
    '{3'd0, 2'd2, 1'b0, 1'b0, 64,   64,   4},  // R2 divide by four
    '{3'd5, 2'd0, 1'b0, 1'b0, 256,  256,  1},  // R1 16x16 form
    '{3'd5, 2'd1, 1'b0, 1'b1, 0,    0,    1},  // R9 16x16 with overlap
    '{3'd4, 2'd1, 1'b1, 1'b1, 0,    0,    1},  // R9 1024 overlapped extended
    '{3'd4, 2'd1, 1'b0, 1'b0, 1024, 1024, 2},  // R4 wrap, 1024 normal
    '{3'd1, 2'd3, 1'b0, 1'b1, 0,    0,    1},  // R9 overlap code 3
    '{3'd6, 2'd0, 1'b0, 1'b1, 0,    0,    1},  // R9 size code 6
    '{3'd1, 2'd1, 1'b0, 1'b0, 128,  128,  2}   // R5 normal, halved strobe
  };

  logic clk = 1'b0;
  logic srst, start, ext_load, in_en, samp_valid;
  logic [2:0] size_sel;
  logic [1:0] ovl_sel;
  logic samp_ready, wr_en, load_flag, block_done, cfg_err;
  logic [AW-1:0] wr_addr;

  always #2 clk = ~clk;

  ovl_load_seq u_dut (
    .clk(clk), .srst(srst), .start(start), .size_sel(size_sel),
    .ovl_sel(ovl_sel), .ext_load(ext_load), .in_en(in_en),
    .samp_valid(samp_valid), .samp_ready(samp_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .load_flag(load_flag), .block_done(block_done),
    .cfg_err(cfg_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;
  logic [AW-1:0] exp_ptr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_load(input vec_t v);
    int writes = 0, flagged = 0, gap_bad = 0, addr_bad = 0;
    int last_t = -1, t = 0, stray = 0;
    bit seen_done = 1'b0;
    @(negedge clk);
    size_sel = v.size; ovl_sel = v.ovl; ext_load = v.ext;
    in_en = 1'b1; samp_valid = 1'b1;
    #0;
    chk(cfg_err == v.err, "R9", "cfg_err", cfg_err, v.err);
    pulse_start();
    if (v.err) begin
      repeat (40) begin
        if (wr_en || load_flag) stray++;
        @(negedge clk);
      end
      chk(stray == 0, "R9", "activity after illegal start", stray, 0);
      return;
    end
    while (!seen_done && t < 6000) begin
      if (wr_en) begin
        if (wr_addr != exp_ptr) addr_bad++;
        exp_ptr = exp_ptr + 1'b1;
        if (last_t >= 0 && (t - last_t) != int'(v.dv)) gap_bad++;
        last_t = t;
        writes++;
        if (load_flag) flagged++;
      end
      if (block_done) begin
        seen_done = 1'b1;
        chk(wr_en == 1'b1, "R8", "done without final write", wr_en, 1);
      end
      t++;
      if (!seen_done) @(negedge clk);
    end
    chk(seen_done, "R8", "block_done seen", seen_done, 1);
    chk(addr_bad == 0, "R4", "address mismatches", addr_bad, 0);
    chk(gap_bad == 0, "R2", "write spacing mismatches", gap_bad, 0);
    chk(writes == int'(v.len), v.ext ? "R6" : "R5", "write count", writes, v.len);
    chk(flagged == int'(v.npts) - 1, "R7", "writes under load_flag", flagged, v.npts - 1);
    repeat (12) begin
      @(negedge clk);
      if (wr_en || block_done) stray++;
    end
    chk(stray == 0, "R8", "writes after completion", stray, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int stray;
    int writes;
    srst = 1'b1; start = 1'b0; size_sel = '0; ovl_sel = '0;
    ext_load = 1'b0; in_en = 1'b0; samp_valid = 1'b0;
    repeat (3) @(negedge clk);
    srst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(wr_en == 1'b0, "R10", "wr_en after reset", wr_en, 0);
    chk(load_flag == 1'b0, "R10", "load_flag after reset", load_flag, 0);
    chk(block_done == 1'b0, "R10", "block_done after reset", block_done, 0);
    chk(wr_addr == '0, "R10", "wr_addr after reset", wr_addr, 0);
    chk(samp_ready == 1'b0, "R3", "ready while idle", samp_ready, 0);

    for (int i = 0; i < NV; i++) run_load(VECS[i]);

    // R3: input enable low blocks acceptance
    @(negedge clk);
    size_sel = 3'd0; ovl_sel = 2'd0; ext_load = 1'b0;
    in_en = 1'b0; samp_valid = 1'b1;
    pulse_start();
    stray = 0;
    repeat (30) begin
      if (wr_en || samp_ready || load_flag) stray++;
      @(negedge clk);
    end
    chk(stray == 0, "R3", "activity with in_en low", stray, 0);
    in_en = 1'b1;
    writes = 0;
    for (int t = 0; t < 500 && !block_done; t++) begin
      @(negedge clk);
      if (wr_en) begin
        if (writes == 0)
          chk(wr_addr == exp_ptr, "R4", "first address after enable", wr_addr, exp_ptr);
        writes++;
      end
    end
    chk(writes == 64, "R3", "writes once enabled", writes, 64);
    exp_ptr = exp_ptr + 11'd64;

    // R10: reset in the middle of a load
    @(negedge clk);
    size_sel = 3'd2; ovl_sel = 2'd0; ext_load = 1'b0;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(load_flag == 1'b1, "R7", "flag high mid-load", load_flag, 1);
    srst = 1'b1;
    @(negedge clk);
    chk(load_flag == 1'b0, "R10", "flag after mid reset", load_flag, 0);
    chk(wr_en == 1'b0, "R10", "wr_en after mid reset", wr_en, 0);
    chk(wr_addr == '0, "R10", "wr_addr after mid reset", wr_addr, 0);
    srst = 1'b0;
    stray = 0;
    repeat (10) begin
      @(negedge clk);
      if (wr_en || samp_ready) stray++;
    end
    chk(stray == 0, "R10", "load abandoned by reset", stray, 0);
    exp_ptr = '0;
    run_load(VECS[0]);  // R10 pointer restarts at zero

    report();
  end
endmodule